// File: doc/BRIEF.md
# Synchronization-Byte Bit-Rate Recovery

This block lets a bus slave learn the serial bit rate at run time instead of taking it from a fixed parameter. Once reset is released it stays deaf to the receive line for a fixed holdoff period. It then waits for the alternating synchronization byte 0x55 and counts system clocks from the start-bit falling edge to the ninth transition that follows it, a span of nine bit periods.

That count goes to an on-chip sequential restoring divider, which is started with a one-cycle strobe and given the count and the constant 9. When the divider finishes it raises a done strobe and returns a quotient and a remainder. The block rounds the quotient into a per-bit sample constant for the receiver. It then derives a 13-bit slot duration and a 26-bit error timeout, registers all three values, and only after that raises a locked flag. The UART and the round sequencer act on that flag.

If the expected transitions do not all arrive within a maximum count, the block drops the attempt and hunts for a new start edge. Once locked, it holds its results until the next reset.

Top module: `baud_sync_recover`

## Requirements
- R1: Receive-line transitions during the first HOLD_CYC clocks after reset release are ignored and produce no measurement.
- R2: After the holdoff, a 1-to-0 transition starts a measurement. The measured count is the number of clocks from that transition to the 9th transition after it. The sync byte is 0x55 sent LSB first after a 0 start bit, followed by a parity bit of 1 and a stop bit of 1, so the line toggles at every bit boundary up to and including the data-to-parity boundary.
- R3: The count is divided by 9 in a 24-bit restoring divider that produces one quotient bit per clock. The divider uses a start strobe and a done strobe, and its remainder is always less than the divisor.
- R4: The bit constant equals the quotient rounded to nearest. It is the quotient plus 1 when twice the remainder is at least 9, and the quotient otherwise.
- R5: The slot time equals bit constant × 13 and the error time equals bit constant × 26.
- R6: All three outputs read 0 while locked_o is 0. locked_o rises only when all three values are valid, and no later than 40 clocks after the final transition reaches rx_i.
- R7: If the count reaches MAX_CNT before the 9th transition, the measurement is abandoned and a new 1-to-0 start transition is awaited. Transitions from the abandoned attempt do not contribute to any later count.
- R8: Once locked, further receive-line activity is ignored. locked_o and all three values hold until reset.
- R9: With a 50 MHz clock and a 19200 bit/s sync byte, the recovered bit constant is 2604.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Asynchronous receive line, idle high |
| locked_o | output | 1 | Bit-rate results valid |
| bit_const_o | output | CNT_W | Clocks per bit (rounded) |
| slot_time_o | output | OUT_W | Clocks per 13-bit slot |
| err_time_o | output | OUT_W | Clocks in the error timeout |

## Verification
The embedded assertions check the following on every cycle:
- the measurement counter never passes its abort limit;
- measurement-complete and divider-done are single-cycle pulses;
- the divider remainder is below the divisor;
- the divider never completes after lock;
- lock, once set, is sticky with stable results.

Only the bench scenarios can show the arithmetic outcome:
- the holdoff suppressing an early byte;
- round-to-nearest on a skewed final edge;
- an aborted partial frame that does not poison the next count;
- recovery of 2604 clocks per bit at 19200 bit/s.

The bench's per-clock reference flags any lock that no valid frame justifies, and any lock that comes late.

// File: rtl/baud_sync_pkg.sv
package baud_sync_pkg;
  typedef enum logic [1:0] {SM_HOLD, SM_HUNT, SM_MEAS, SM_DONE} meter_state_e;
  localparam int unsigned SPAN_BITS_DEF = 9;
  localparam int unsigned SLOT_MULT_DEF = 13;
  localparam int unsigned ERR_MULT_DEF  = 26;
endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= rx_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], rx_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];

  assign edge_o = sync_q[STAGES-1] ^ prev_q;
  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/span_meter.sv
module span_meter
  import baud_sync_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned HOLD_CYC  = 50000,
  parameter int unsigned MAX_CNT   = 1000000,
  parameter int unsigned SPAN_BITS = SPAN_BITS_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             edge_i,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_cnt_o
);
  localparam int unsigned HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int unsigned EDGE_W = $clog2(SPAN_BITS + 1);

  meter_state_e      state_q;
  logic [HOLD_W-1:0] hold_q;
  logic [EDGE_W-1:0] edges_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SM_HOLD;
      hold_q     <= '0;
      edges_q    <= '0;
      cnt_q      <= '0;
      meas_vld_o <= 1'b0;
      meas_cnt_o <= '0;
    end else begin
      meas_vld_o <= 1'b0;
      unique case (state_q)
        SM_HOLD: begin
          if (hold_q == HOLD_W'(HOLD_CYC - 1)) state_q <= SM_HUNT;
          else hold_q <= hold_q + 1'b1;
        end
        SM_HUNT: begin
          if (fall_i) begin
            state_q <= SM_MEAS;
            cnt_q   <= CNT_W'(1);
            edges_q <= '0;
          end
        end
        SM_MEAS: begin
          if (edge_i && edges_q == EDGE_W'(SPAN_BITS - 1)) begin
            meas_cnt_o <= cnt_q;
            meas_vld_o <= 1'b1;
            state_q    <= SM_DONE;
          end else if (cnt_q == CNT_W'(MAX_CNT)) begin
            state_q <= SM_HUNT;   // abandon attempt
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (edge_i) edges_q <= edges_q + 1'b1;
          end
        end
        default: ;                // SM_DONE: line ignored
      endcase
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_CNT));

  // R2
  meas_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_vld_o |=> !meas_vld_o);

  // R1
  hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SM_HOLD) |=> (state_q == SM_HOLD || state_q == SM_HUNT));
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned STEP_W = $clog2(W + 1);

  logic [W-1:0]      quo_q, rem_q, div_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q;
  logic [W:0]        shifted, diff;
  logic              fits;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, div_q};
  assign fits    = ~diff[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      div_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        quo_q  <= dividend_i;
        rem_q  <= '0;
        div_q  <= divisor_i;
        step_q <= STEP_W'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        quo_q  <= {quo_q[W-2:0], fits};
        rem_q  <= fits ? diff[W-1:0] : shifted[W-1:0];
        step_q <= step_q - 1'b1;
        if (step_q == STEP_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;
  assign rem_o  = rem_q;

  // R3
  rem_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rem_q < div_q);

  // R3
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/baud_sync_recover.sv
module baud_sync_recover
  import baud_sync_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned HOLD_CYC    = 50000,
  parameter int unsigned MAX_CNT     = 1000000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SPAN_BITS   = SPAN_BITS_DEF,
  parameter int unsigned SLOT_MULT   = SLOT_MULT_DEF,
  parameter int unsigned ERR_MULT    = ERR_MULT_DEF,
  localparam int unsigned OUT_W      = CNT_W + $clog2(ERR_MULT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  output logic             locked_o,
  output logic [CNT_W-1:0] bit_const_o,
  output logic [OUT_W-1:0] slot_time_o,
  output logic [OUT_W-1:0] err_time_o
);
  logic             fall, any_edge, meas_vld, div_done, rnd_up;
  logic [CNT_W-1:0] meas_cnt, quot, rem;
  logic [CNT_W-1:0] bit_q;
  logic [OUT_W-1:0] slot_q, err_q;
  logic             scale_q, locked_q;

  rx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .rx_i, .fall_o(fall), .edge_o(any_edge)
  );

  span_meter #(
    .CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC), .MAX_CNT(MAX_CNT), .SPAN_BITS(SPAN_BITS)
  ) u_meter (
    .clk_i, .rst_ni, .fall_i(fall), .edge_i(any_edge),
    .meas_vld_o(meas_vld), .meas_cnt_o(meas_cnt)
  );

  seq_divider #(.W(CNT_W)) u_div (
    .clk_i, .rst_ni, .start_i(meas_vld), .dividend_i(meas_cnt),
    .divisor_i(CNT_W'(SPAN_BITS)), .done_o(div_done), .quot_o(quot), .rem_o(rem)
  );

  assign rnd_up = {rem, 1'b0} >= {1'b0, CNT_W'(SPAN_BITS)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q    <= '0;
      slot_q   <= '0;
      err_q    <= '0;
      scale_q  <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      scale_q <= 1'b0;
      if (div_done && !locked_q) begin
        bit_q   <= quot + CNT_W'(rnd_up);
        scale_q <= 1'b1;
      end
      if (scale_q) begin
        slot_q   <= OUT_W'(bit_q) * OUT_W'(SLOT_MULT);
        err_q    <= OUT_W'(bit_q) * OUT_W'(ERR_MULT);
        locked_q <= 1'b1;
      end
    end
  end

  assign locked_o    = locked_q;
  assign bit_const_o = locked_q ? bit_q  : '0;
  assign slot_time_o = locked_q ? slot_q : '0;
  assign err_time_o  = locked_q ? err_q  : '0;

  // R8
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q && $stable(bit_q) && $stable(slot_q) && $stable(err_q));

  // R8
  no_div_after_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |-> !div_done && !meas_vld);

  // R6
  lock_after_scale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(scale_q));
endmodule

// File: tb/tb_baud_sync_recover.sv
module tb_baud_sync_recover;
  localparam int HOLD = 300;
  localparam int MAXC = 30000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx = 1'b1;
  logic        locked_o;
  logic [23:0] bit_const_o;
  logic [28:0] slot_time_o, err_time_o;

  always #2 clk = ~clk;

  baud_sync_recover #(.HOLD_CYC(HOLD), .MAX_CNT(MAXC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx), .locked_o(locked_o),
    .bit_const_o(bit_const_o), .slot_time_o(slot_time_o), .err_time_o(err_time_o)
  );

  int total = 0, bad = 0, cyc = 0;
  bit exp_vld = 0;
  int exp_bit = 0, exp_slot = 0, exp_err = 0, deadline = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // per-clock reference comparison
  always @(posedge clk) begin
    cyc++;
    #1;
    if (rst_ni) begin
      if (!exp_vld)
        chk(!locked_o && bit_const_o == 0, "R1/R7 lock without valid frame",
            int'(bit_const_o), 0);
      else if (locked_o) begin
        chk(int'(bit_const_o) == exp_bit, "R4 bit constant", int'(bit_const_o), exp_bit);
        chk(int'(slot_time_o) == exp_slot, "R5 slot time", int'(slot_time_o), exp_slot);
        chk(int'(err_time_o) == exp_err, "R5 error time", int'(err_time_o), exp_err);
      end else begin
        chk(bit_const_o == 0 && slot_time_o == 0 && err_time_o == 0,
            "R6 outputs zero while unlocked", int'(slot_time_o), 0);
        chk(cyc <= deadline, "R6 lock latency", cyc, deadline);
      end
    end
  end

  task automatic do_reset();
    rst_ni  = 1'b0;
    exp_vld = 0;
    rx      = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // t[k]: clock offset of transition k from the start edge; n: transitions driven
  task automatic frame_t(input int t[10], input int n, input bit expect_lock);
    int cnt, q, r, b;
    @(negedge clk);
    rx = 1'b0;
    for (int k = 1; k < n; k++) begin
      repeat (t[k] - t[k-1]) @(negedge clk);
      rx = k[0];
      if (k == 9 && expect_lock) begin
        cnt = t[9];
        q = cnt / 9;
        r = cnt % 9;
        b = q + ((2 * r >= 9) ? 1 : 0);
        exp_bit  = b;
        exp_slot = b * 13;
        exp_err  = b * 26;
        deadline = cyc + 40;
        exp_vld  = 1;
      end
    end
    rx = 1'b1;
    repeat (3 * (t[1] - t[0])) @(negedge clk);
  endtask

  task automatic frame(input int b, input int skew, input int n, input bit expect_lock);
    int t[10];
    for (int k = 0; k < 10; k++) t[k] = k * b;
    t[9] = t[9] + skew;
    frame_t(t, n, expect_lock);
  endtask

  task automatic wait_lock();
    for (int i = 0; i < 60 && !locked_o; i++) @(negedge clk);
  endtask

  initial begin
    int t[10];
    do_reset();
    @(negedge clk);
    chk(locked_o == 0 && bit_const_o == 0, "R6 reset state", int'(locked_o), 0);

    // holdoff: early byte must be ignored
    repeat (20) @(negedge clk);
    frame(20, 0, 10, 0);
    repeat (HOLD) @(negedge clk);
    chk(locked_o == 0, "R1 early byte ignored", int'(locked_o), 0);
    frame(25, 0, 10, 1);
    wait_lock();
    chk(int'(bit_const_o) == 25, "R1/R2 bit constant after holdoff", int'(bit_const_o), 25);
    chk(int'(slot_time_o) == 325, "R5 slot", int'(slot_time_o), 325);
    chk(int'(err_time_o) == 650, "R5 error", int'(err_time_o), 650);

    // rounding up: count 365 = 9*40 + 5
    do_reset();
    repeat (HOLD + 10) @(negedge clk);
    frame(40, 5, 10, 1);
    wait_lock();
    chk(int'(bit_const_o) == 41, "R3/R4 round up", int'(bit_const_o), 41);

    // rounding down: count 364 = 9*40 + 4
    do_reset();
    repeat (HOLD + 10) @(negedge clk);
    frame(40, 4, 10, 1);
    wait_lock();
    chk(int'(bit_const_o) == 40, "R3/R4 round down", int'(bit_const_o), 40);

    // traffic after lock
    frame(17, 0, 10, 0);
    repeat (50) @(negedge clk);
    chk(locked_o == 1 && int'(bit_const_o) == 40, "R8 hold after lock",
        int'(bit_const_o), 40);

    // partial frame then abort and recovery
    do_reset();
    repeat (HOLD + 10) @(negedge clk);
    frame(20, 0, 4, 0);
    repeat (MAXC + 100) @(negedge clk);
    chk(locked_o == 0, "R7 aborted measurement", int'(locked_o), 0);
    frame(30, 0, 10, 1);
    wait_lock();
    chk(int'(bit_const_o) == 30, "R7 recovery after abort", int'(bit_const_o), 30);

    // 19200 bit/s at 50 MHz
    do_reset();
    repeat (HOLD + 10) @(negedge clk);
    for (int k = 0; k < 10; k++) t[k] = (k * 50000000 + 9600) / 19200;
    frame_t(t, 10, 1);
    wait_lock();
    chk(int'(bit_const_o) == 2604, "R9 19200 bit/s", int'(bit_const_o), 2604);
    chk(int'(slot_time_o) == 2604 * 13, "R9/R5 slot", int'(slot_time_o), 2604 * 13);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule